// File: doc/BRIEF.md
# Reference-Counted Watch Slot Allocator

This block owns a small set of hardware watch slots that a debug unit's address comparators read. Software-side agents send insert and remove requests, each carrying an aligned address and a 4-bit type/length code. The allocator keeps a mirror of every slot's address, a per-slot reference count and a packed 32-bit control word. It answers every request with a success or failure flag. When a slot's address or the control word changes, it pulses write strobes toward the comparator registers.

An insert that exactly repeats an active watch shares that slot and bumps its count, so no second slot is used. A slot is released only after as many removes as there were inserts. An initialization request wipes all slot state and the sticky hit-status mirror. Requests are accepted only while the block is idle. Each request completes in a fixed three-cycle sequence: capture, scan, then commit.

Top module: `watchSlotAlloc`

## Requirements
- R1: After reset, all slot addresses, counts, the control word and the status mirror are zero, and busy, done, ok, the address strobes and the control strobe are low.
- R2: A request sampled with reqValid while busy is low produces exactly one done pulse, one cycle long, visible after the third rising edge counted from the accepting edge. busy is high for the two cycles between. A reqValid seen while busy is high is ignored.
- R3: When an insert finds no matching slot, it takes the lowest-numbered vacant slot. A slot is vacant when both of its enable bits (control bits 2i and 2i+1) are zero. The insert records the address, sets the count to 1, writes the code into control bits [16+4i+3:16+4i], sets the local enable bit 2i and sets the exact-match flag at bit 8. It returns ok=1.
- R4: An insert whose address and code equal those of an occupied slot increments that slot's count and allocates nothing new. It returns ok=1 with no strobes.
- R5: An insert with an address already in use but a different code is not a match and takes a new slot.
- R6: An insert with no match and no vacant slot returns ok=0, raises no strobe and changes no address, count or control bit.
- R7: A remove decrements the count of every occupied slot with the same address and code and returns ok=1. A remove that matches no slot returns ok=0 and changes nothing.
- R8: When a remove brings a count to zero, that slot's address is cleared and both of its enable bits are cleared, so the slot becomes vacant and can be taken again.
- R9: Reference counts are 8 bits wide and stay at 255 on further matching inserts, which still return ok=1.
- R10: An initialization request (reqOp=2) clears all addresses, all counts, the control word and the status mirror, pulses every strobe, and returns ok=1. Insert is reqOp=0 and remove is reqOp=1.
- R11: Control bits 10 through 15 are always zero.
- R12: addrWe[i] pulses together with done exactly when slot i's address is written, and ctrlWe pulses with done whenever enable bits or fields are written.
- R13: Each hitIn[i] that is high at a clock edge sets statusMirror[i], which then stays set until an initialization request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present (taken only when idle) |
| reqOp | input | 2 | 0 insert, 1 remove, 2 initialize, 3 no operation |
| reqAddr | input | 32 | Aligned watch address |
| reqCode | input | 4 | Type/length code |
| hitIn | input | 4 | Per-slot hit reports from comparators |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Result flag, valid with done |
| ctrlWord | output | 32 | Packed control word |
| slotAddrFlat | output | 128 | Slot address mirrors, slot i at [32i+31:32i] |
| slotCntFlat | output | 32 | Reference counts, slot i at [8i+7:8i] |
| statusMirror | output | 4 | Sticky hit status |
| addrWe | output | 4 | Per-slot address write strobes |
| ctrlWe | output | 1 | Control word write strobe |

## Verification
The bench goes after slot sharing. An allocator that ignored the code when matching would merge a read/write watch into a write-only slot, so the different-code insert would not take a new slot. Filling all four slots and then inserting again exposes a design that overwrites slot 3 or wraps to slot 0 instead of failing cleanly. The free path is driven by two inserts and two removes: a design that frees on the first remove loses the second owner's watch, and one that leaves the enable bits set never reuses the hole. Hammering one slot past 255 inserts catches a wrapping counter, which would silently free a live slot on the next remove. A request issued while busy checks that a second command cannot sneak in mid-scan.

// File: rtl/wsaPkg.sv
package wsaPkg;
  localparam int CODE_W      = 4;
  localparam int CTRL_W      = 32;
  localparam int EN_W        = 2;
  localparam int FIELD_BASE  = 16;
  localparam int EXACT_BIT   = 8;
  localparam int RSV_LO      = 10;
  localparam int RSV_HI      = 15;

  typedef enum logic [1:0] {
    OP_INSERT = 2'd0,
    OP_REMOVE = 2'd1,
    OP_INIT   = 2'd2,
    OP_NOP    = 2'd3
  } wsaOp_e;

  typedef struct packed {
    logic capture;
    logic scan;
    logic commit;
  } wsaStrobe_t;
endpackage

// File: rtl/wsaLowestPick.sv
module wsaLowestPick #(
  parameter int N = 4
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] pick,
  output logic         any
);
  logic [N:0] below;
  assign below[0] = 1'b0;
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : gPick
      assign pick[i]    = vec[i] & ~below[i];
      assign below[i+1] = below[i] | vec[i];
    end
  endgenerate
  assign any = below[N];
endmodule

// File: rtl/wsaControl.sv
module wsaControl
  import wsaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output wsaStrobe_t stb,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_COMMIT} state_e;
  state_e stateQ, stateN;
  logic   doneQ;

  always_comb begin
    stateN = stateQ;
    stb    = '0;
    case (stateQ)
      S_IDLE:   if (reqValid) begin stb.capture = 1'b1; stateN = S_SCAN; end
      S_SCAN:   begin stb.scan = 1'b1; stateN = S_COMMIT; end
      S_COMMIT: begin stb.commit = 1'b1; stateN = S_IDLE; end
      default:  stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateN;
      doneQ  <= stb.commit;
    end
  end

  assign busy = (stateQ != S_IDLE);
  assign done = doneQ;
endmodule

// File: rtl/wsaDatapath.sv
module wsaDatapath
  import wsaPkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  wsaStrobe_t          stb,
  input  logic [1:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [CODE_W-1:0]   reqCode,
  input  logic [N-1:0]        hitIn,
  output logic                ok,
  output logic [CTRL_W-1:0]   ctrlWord,
  output logic [N*ADDR_W-1:0] slotAddrFlat,
  output logic [N*CNT_W-1:0]  slotCntFlat,
  output logic [N-1:0]        statusMirror,
  output logic [N-1:0]        addrWe,
  output logic                ctrlWe
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addrQ [N];
  logic [ADDR_W-1:0] addrN [N];
  logic [CNT_W-1:0]  cntQ  [N];
  logic [CNT_W-1:0]  cntN  [N];
  logic [CTRL_W-1:0] ctrlQ, ctrlN;
  logic [N-1:0]      statusQ;

  wsaOp_e            opQ;
  logic [ADDR_W-1:0] opAddrQ;
  logic [CODE_W-1:0] opCodeQ;

  logic [N-1:0] matchRaw, vacRaw, matchQ, vacQ;
  logic [N-1:0] matchPick, vacPick;
  logic         matchAny, vacAny;

  logic [N-1:0] addrWeN, addrWeQ;
  logic         ctrlWeN, ctrlWeQ, okN, okQ;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : gScan
      logic occupied;
      assign occupied    = |ctrlQ[EN_W*g +: EN_W];
      assign vacRaw[g]   = ~occupied;
      assign matchRaw[g] = occupied && (addrQ[g] == opAddrQ) &&
                           (ctrlQ[FIELD_BASE + CODE_W*g +: CODE_W] == opCodeQ);
      assign slotAddrFlat[ADDR_W*g +: ADDR_W] = addrQ[g];
      assign slotCntFlat[CNT_W*g +: CNT_W]    = cntQ[g];
    end
  endgenerate

  wsaLowestPick #(.N(N)) uMatchPick (.vec(matchQ), .pick(matchPick), .any(matchAny));
  wsaLowestPick #(.N(N)) uVacPick   (.vec(vacQ),   .pick(vacPick),   .any(vacAny));

  always_comb begin
    addrN   = addrQ;
    cntN    = cntQ;
    ctrlN   = ctrlQ;
    addrWeN = '0;
    ctrlWeN = 1'b0;
    okN     = 1'b0;
    case (opQ)
      OP_INSERT: begin
        if (matchAny) begin
          okN = 1'b1;
          for (int i = 0; i < N; i++) begin
            if (matchPick[i] && (cntQ[i] != CNT_MAX)) cntN[i] = cntQ[i] + CNT_ONE;
          end
        end else if (vacAny) begin
          okN     = 1'b1;
          ctrlWeN = 1'b1;
          for (int i = 0; i < N; i++) begin
            if (vacPick[i]) begin
              addrN[i] = opAddrQ;
              cntN[i]  = CNT_ONE;
              ctrlN[FIELD_BASE + CODE_W*i +: CODE_W] = opCodeQ;
              ctrlN[EN_W*i] = 1'b1;
              addrWeN[i] = 1'b1;
            end
          end
          ctrlN[EXACT_BIT]       = 1'b1;
          ctrlN[RSV_HI:RSV_LO]   = '0;
        end
      end
      OP_REMOVE: begin
        okN = |matchQ;
        for (int i = 0; i < N; i++) begin
          if (matchQ[i]) begin
            cntN[i] = cntQ[i] - CNT_ONE;
            if (cntQ[i] == CNT_ONE) begin
              addrN[i] = '0;
              ctrlN[EN_W*i +: EN_W] = '0;
              addrWeN[i] = 1'b1;
              ctrlWeN    = 1'b1;
            end
          end
        end
      end
      OP_INIT: begin
        okN     = 1'b1;
        ctrlN   = '0;
        ctrlWeN = 1'b1;
        addrWeN = '1;
        for (int i = 0; i < N; i++) begin
          addrN[i] = '0;
          cntN[i]  = '0;
        end
      end
      default: okN = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        addrQ[i] <= '0;
        cntQ[i]  <= '0;
      end
      ctrlQ   <= '0;
      statusQ <= '0;
      opQ     <= OP_NOP;
      opAddrQ <= '0;
      opCodeQ <= '0;
      matchQ  <= '0;
      vacQ    <= '0;
      addrWeQ <= '0;
      ctrlWeQ <= 1'b0;
      okQ     <= 1'b0;
    end else begin
      if (stb.capture) begin
        opQ     <= wsaOp_e'(reqOp);
        opAddrQ <= reqAddr;
        opCodeQ <= reqCode;
      end
      if (stb.scan) begin
        matchQ <= matchRaw;
        vacQ   <= vacRaw;
      end
      if (stb.commit) begin
        addrQ   <= addrN;
        cntQ    <= cntN;
        ctrlQ   <= ctrlN;
        addrWeQ <= addrWeN;
        ctrlWeQ <= ctrlWeN;
        okQ     <= okN;
      end else begin
        addrWeQ <= '0;
        ctrlWeQ <= 1'b0;
      end
      if (stb.commit && opQ == OP_INIT) statusQ <= '0;
      else                              statusQ <= statusQ | hitIn;
    end
  end

  assign ok           = okQ;
  assign ctrlWord     = ctrlQ;
  assign statusMirror = statusQ;
  assign addrWe       = addrWeQ;
  assign ctrlWe       = ctrlWeQ;
endmodule

// File: rtl/watchSlotAlloc.sv
module watchSlotAlloc
  import wsaPkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [3:0]          reqCode,
  input  logic [N-1:0]        hitIn,
  output logic                busy,
  output logic                done,
  output logic                ok,
  output logic [31:0]         ctrlWord,
  output logic [N*ADDR_W-1:0] slotAddrFlat,
  output logic [N*CNT_W-1:0]  slotCntFlat,
  output logic [N-1:0]        statusMirror,
  output logic [N-1:0]        addrWe,
  output logic                ctrlWe
);
  wsaStrobe_t stb;

  wsaControl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .stb(stb), .busy(busy), .done(done)
  );

  wsaDatapath #(.N(N), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqCode(reqCode), .hitIn(hitIn),
    .ok(ok), .ctrlWord(ctrlWord), .slotAddrFlat(slotAddrFlat),
    .slotCntFlat(slotCntFlat), .statusMirror(statusMirror),
    .addrWe(addrWe), .ctrlWe(ctrlWe)
  );
endmodule

// File: rtl/watchSlotAllocChecker.sv
module watchSlotAllocChecker #(
  parameter int N     = 4,
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               done,
  input logic               ok,
  input logic [31:0]        ctrlWord,
  input logic [N*CNT_W-1:0] slotCntFlat,
  input logic [N-1:0]       addrWe,
  input logic               ctrlWe
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[15:10] == 6'd0);

  assert_strobe_with_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((|addrWe) || ctrlWe) |-> done);

  assert_fail_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !ok) |-> (!ctrlWe && addrWe == '0));

  assert_count_moves_at_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(slotCntFlat) |-> done);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : gSlot
      assert_occupied_count_R8: assert property (@(posedge clk) disable iff (!rstN)
        (ctrlWord[2*g +: 2] == 2'b00) == (slotCntFlat[CNT_W*g +: CNT_W] == '0));
    end
  endgenerate
endmodule

bind watchSlotAlloc watchSlotAllocChecker #(.N(N), .CNT_W(CNT_W)) uChecker (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .ok(ok),
  .ctrlWord(ctrlWord), .slotCntFlat(slotCntFlat), .addrWe(addrWe), .ctrlWe(ctrlWe)
);

// File: tb/tb_watchSlotAlloc.sv
module tb_watchSlotAlloc;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqCode = '0;
  logic [N-1:0] hitIn = '0;
  logic        busy, done, ok, ctrlWe;
  logic [31:0] ctrlWord;
  logic [N*32-1:0] slotAddrFlat;
  logic [N*8-1:0]  slotCntFlat;
  logic [N-1:0] statusMirror, addrWe;

  always #2 clk = ~clk;

  watchSlotAlloc dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqCode(reqCode), .hitIn(hitIn), .busy(busy), .done(done), .ok(ok),
    .ctrlWord(ctrlWord), .slotAddrFlat(slotAddrFlat), .slotCntFlat(slotCntFlat),
    .statusMirror(statusMirror), .addrWe(addrWe), .ctrlWe(ctrlWe)
  );

  int checks = 0;
  int errors = 0;

  // reference model built from the requirements
  logic [31:0] mAddr [N];
  int          mCnt  [N];
  logic [31:0] mCtrl;

  // values captured at the done cycle
  int          lat;
  logic        gotOk;
  logic [N-1:0] gotAddrWe;
  logic        gotCtrlWe;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mInit();
    for (int i = 0; i < N; i++) begin mAddr[i] = '0; mCnt[i] = 0; end
    mCtrl = '0;
  endtask

  function automatic bit mOcc(input int i);
    return mCtrl[2*i +: 2] != 2'b00;
  endfunction

  task automatic mInsert(input logic [31:0] a, input logic [3:0] c, output logic okE,
                         output logic [N-1:0] weE, output logic cweE);
    okE = 1'b0; weE = '0; cweE = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (mOcc(i) && mAddr[i] == a && mCtrl[16+4*i +: 4] == c) begin
        if (mCnt[i] < 255) mCnt[i]++;
        okE = 1'b1;
        return;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (!mOcc(i)) begin
        mAddr[i] = a; mCnt[i] = 1;
        mCtrl[16+4*i +: 4] = c; mCtrl[2*i] = 1'b1; mCtrl[8] = 1'b1;
        okE = 1'b1; weE[i] = 1'b1; cweE = 1'b1;
        return;
      end
    end
  endtask

  task automatic mRemove(input logic [31:0] a, input logic [3:0] c, output logic okE,
                         output logic [N-1:0] weE, output logic cweE);
    okE = 1'b0; weE = '0; cweE = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (mOcc(i) && mAddr[i] == a && mCtrl[16+4*i +: 4] == c) begin
        okE = 1'b1;
        mCnt[i]--;
        if (mCnt[i] == 0) begin
          mAddr[i] = '0; mCtrl[2*i +: 2] = 2'b00; weE[i] = 1'b1; cweE = 1'b1;
        end
      end
    end
  endtask

  // issue one request and wait for done; records latency and outputs
  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [3:0] c);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqCode = c;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) reqValid = 1'b0;
    end while (!done && lat < 20);
    gotOk = ok; gotAddrWe = addrWe; gotCtrlWe = ctrlWe;
  endtask

  task automatic compareState(input string req);
    chk({req, " ctrl"}, ctrlWord, mCtrl);
    chk("R11 reserved bits", ctrlWord[15:10], 6'd0);
    for (int i = 0; i < N; i++) begin
      chk({req, " addr"}, slotAddrFlat[32*i +: 32], mAddr[i]);
      chk({req, " count"}, slotCntFlat[8*i +: 8], mCnt[i][7:0]);
    end
  endtask

  task automatic doInsert(input string req, input logic [31:0] a, input logic [3:0] c);
    logic okE; logic [N-1:0] weE; logic cweE;
    mInsert(a, c, okE, weE, cweE);
    issue(2'd0, a, c);
    chk({req, " ok"}, gotOk, okE);
    chk("R12 addr strobe", gotAddrWe, weE);
    chk("R12 ctrl strobe", gotCtrlWe, cweE);
    compareState(req);
  endtask

  task automatic doRemove(input string req, input logic [31:0] a, input logic [3:0] c);
    logic okE; logic [N-1:0] weE; logic cweE;
    mRemove(a, c, okE, weE, cweE);
    issue(2'd1, a, c);
    chk({req, " ok"}, gotOk, okE);
    chk("R12 addr strobe", gotAddrWe, weE);
    chk("R12 ctrl strobe", gotCtrlWe, cweE);
    compareState(req);
  endtask

  task automatic doInitReq();
    mInit();
    issue(2'd2, 32'h0, 4'h0);
    chk("R10 ok", gotOk, 1'b1);
    chk("R10 addr strobes", gotAddrWe, {N{1'b1}});
    chk("R10 ctrl strobe", gotCtrlWe, 1'b1);
    chk("R10 status cleared", statusMirror, '0);
    compareState("R10");
  endtask

  task automatic tResetState();
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 ok", ok, 1'b0);
    chk("R1 strobes", {addrWe, ctrlWe}, '0);
    chk("R1 status", statusMirror, '0);
    compareState("R1");
  endtask

  task automatic tAllocLatency();
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; reqAddr = 32'h1000; reqCode = 4'h1;
    @(negedge clk); reqValid = 1'b0;
    chk("R2 busy cycle1", busy, 1'b1);
    chk("R2 no early done", done, 1'b0);
    @(negedge clk);
    chk("R2 busy cycle2", busy, 1'b1);
    chk("R2 no early done", done, 1'b0);
    @(negedge clk);
    chk("R2 done at third edge", done, 1'b1);
    chk("R2 idle with done", busy, 1'b0);
    chk("R3 ok", ok, 1'b1);
    chk("R12 addr strobe slot0", addrWe, 4'b0001);
    chk("R12 ctrl strobe", ctrlWe, 1'b1);
    @(negedge clk);
    chk("R2 done one cycle", done, 1'b0);
    chk("R12 strobes drop", {addrWe, ctrlWe}, '0);
    mAddr[0] = 32'h1000; mCnt[0] = 1; mCtrl[16 +: 4] = 4'h1; mCtrl[0] = 1'b1; mCtrl[8] = 1'b1;
    chk("R3 code field slot0", ctrlWord[19:16], 4'h1);
    chk("R3 local enable slot0", ctrlWord[1:0], 2'b01);
    chk("R3 exact flag", ctrlWord[8], 1'b1);
    compareState("R3");
  endtask

  task automatic tReuse();
    doInsert("R4 reuse", 32'h1000, 4'h1);
    chk("R4 count two", slotCntFlat[7:0], 8'd2);
    chk("R4 slot1 untouched", slotCntFlat[15:8], 8'd0);
  endtask

  task automatic tDiffCode();
    doInsert("R5 new code", 32'h1000, 4'hD);
    chk("R5 slot1 taken", slotAddrFlat[63:32], 32'h1000);
    chk("R5 slot1 code", ctrlWord[23:20], 4'hD);
  endtask

  task automatic tFull();
    doInsert("R3 slot2", 32'h2000, 4'h5);
    doInsert("R3 slot3", 32'h3004, 4'hF);
    doInsert("R6 full", 32'h4000, 4'h1);
    chk("R6 fails", gotOk, 1'b0);
  endtask

  task automatic tRemoveAndFree();
    doRemove("R7 miss", 32'h5000, 4'h1);
    chk("R7 miss fails", gotOk, 1'b0);
    doRemove("R7 decrement", 32'h1000, 4'h1);
    chk("R7 count one", slotCntFlat[7:0], 8'd1);
    chk("R7 still enabled", ctrlWord[1:0], 2'b01);
    doRemove("R8 free", 32'h1000, 4'h1);
    chk("R8 addr cleared", slotAddrFlat[31:0], 32'h0);
    chk("R8 enables cleared", ctrlWord[1:0], 2'b00);
    doInsert("R8 hole reused", 32'h6000, 4'h3);
    chk("R8 slot0 reused", slotAddrFlat[31:0], 32'h6000);
  endtask

  task automatic tSaturate();
    for (int k = 0; k < 256; k++) doInsert("R9 saturate", 32'h2000, 4'h5);
    chk("R9 stuck at 255", slotCntFlat[23:16], 8'd255);
    doInsert("R9 saturated insert", 32'h2000, 4'h5);
    chk("R9 ok at max", gotOk, 1'b1);
    doRemove("R9 decrement from max", 32'h2000, 4'h5);
    chk("R9 count 254", slotCntFlat[23:16], 8'd254);
  endtask

  task automatic tStatus();
    @(negedge clk); hitIn = 4'b0100;
    @(negedge clk); hitIn = 4'b0000;
    chk("R13 bit set", statusMirror, 4'b0100);
    @(negedge clk); hitIn = 4'b0001;
    @(negedge clk); hitIn = 4'b0000;
    @(negedge clk);
    chk("R13 sticky", statusMirror, 4'b0101);
  endtask

  task automatic tBusyIgnore();
    logic okE; logic [N-1:0] weE; logic cweE;
    mInsert(32'h7000, 4'h1, okE, weE, cweE);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; reqAddr = 32'h7000; reqCode = 4'h1;
    @(negedge clk);
    reqAddr = 32'h8000; reqCode = 4'h9;   // arrives while busy
    @(negedge clk); reqValid = 1'b0;
    @(negedge clk);
    chk("R2 first done", done, 1'b1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R2 no second done", done, 1'b0);
    end
    compareState("R2 busy request ignored");
  endtask

  initial begin
    mInit();
    repeat (3) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tAllocLatency();
    tReuse();
    tDiffCode();
    tFull();
    tRemoveAndFree();
    tSaturate();
    tStatus();
    doInitReq();
    tBusyIgnore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule